// File: doc/BRIEF.md
# Request-to-Send Pin Interface

This block sits between three active-low external pins and the transmit scheduler of a message controller. Each pin belongs to the transmit buffer with the same index. When a pin is set to hardware request mode, a high-to-low transition on it raises that buffer's transmit request through a single-cycle set pulse. The pin can then be tied straight to another device's receive-buffer-full output, which goes low, and a reception starts a transmission without host involvement. When a pin is set to digital-input mode it raises no request, and the host uses it only as a readable input.

The pins are asynchronous. Each one passes through a synchronizer chain before the edge detector looks at it. The host writes the per-pin mode bits, and it can read back both the mode bits and the synchronized pin levels. The mode bits change only while the controller is in configuration mode.

Top module: `rts_pin_if`

## Requirements
- R1: Pin k (bit k of `pin_n`) drives only bit k of `req_set`. Several pins that fall together each give their own pulse.
- R2: Bit k of the mode register selects the function of pin k: 1 is hardware request-to-send and 0 is digital input. `mode_q` reads the register back.
- R3: In request mode, a pin that is low at a rising clock edge, after it was high at the edge before, makes its `req_set` bit high for exactly one cycle. The bit is high after the third rising edge, counted from the first edge that samples the pin low, and low again after the fourth.
- R4: A pin held low raises no further pulses. Only a new high-to-low transition raises another pulse.
- R5: In digital-input mode a pin never produces a `req_set` pulse, whatever transitions it makes.
- R6: A write (`cfg_wr` high) updates the mode register only while `cfg_mode` is high. A write while `cfg_mode` is low leaves `mode_q` unchanged.
- R7: In either mode, `pin_level` shows each pin's level two rising edges after the pin is sampled.
- R8: After reset all mode bits are 0, `req_set` is 0 and `pin_level` reads all ones. A pin that is already low during reset produces no request, even if its pin is later switched to request mode while it is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | NUM_PINS | Asynchronous active-low request pins |
| cfg_mode | input | 1 | High while the controller is in configuration mode |
| cfg_wr | input | 1 | Write strobe for the mode register |
| cfg_wdata | input | NUM_PINS | Mode bits to write (1 = request, 0 = digital input) |
| mode_q | output | NUM_PINS | Current mode bits |
| pin_level | output | NUM_PINS | Synchronized pin levels |
| req_set | output | NUM_PINS | Single-cycle set pulses to the buffer request bits |

## Verification
The assertions check four conditions on every cycle:
- No pulse lasts longer than one cycle.
- A pulse appears only for a pin whose mode bit was set.
- A pulse always follows a synchronized low level.
- The mode register holds its value unless a write arrives during configuration mode.

The bench scenarios are the only place that shows the exact three-edge latency and the index mapping. They also show that a held-low pin stays silent, that a pin low during reset stays quiet, and that levels remain readable in digital-input mode.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic {
    PM_GPIO = 1'b0,
    PM_RTS  = 1'b1
  } pin_mode_e;

  localparam int unsigned DEF_PINS   = 3;
  localparam int unsigned DEF_STAGES = 2;
endpackage

// File: rtl/rts_sync.sv
module rts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  // idle level of an active-low pin is high
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rts_cfg.sv
module rts_cfg #(
  parameter int unsigned NUM_PINS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_mode,
  input  logic                wr_en,
  input  logic [NUM_PINS-1:0] wr_data,
  output logic [NUM_PINS-1:0] mode_q
);
  import rts_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)                    mode_q <= {NUM_PINS{PM_GPIO}};
    else if (cfg_mode && wr_en) mode_q <= wr_data;
  end

  // R6
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_mode && wr_en) |=> $stable(mode_q));
endmodule

// File: rtl/rts_fall.sv
module rts_fall #(
  parameter int unsigned NUM_PINS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] lvl,
  input  logic [NUM_PINS-1:0] mode,
  output logic [NUM_PINS-1:0] req_q
);
  import rts_pkg::*;

  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] fall;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++)
      fall[i] = prev_q[i] && !lvl[i] && (mode[i] == PM_RTS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '1;
      req_q  <= '0;
    end else begin
      prev_q <= lvl;
      req_q  <= fall;
    end
  end

  // R3
  req_after_low_chk: assert property (@(posedge clk) disable iff (rst)
    |req_q |-> ((req_q & $past(lvl)) == '0));
endmodule

// File: rtl/rts_pin_if.sv
module rts_pin_if #(
  parameter int unsigned NUM_PINS    = rts_pkg::DEF_PINS,
  parameter int unsigned SYNC_STAGES = rts_pkg::DEF_STAGES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_n,
  input  logic                cfg_mode,
  input  logic                cfg_wr,
  input  logic [NUM_PINS-1:0] cfg_wdata,
  output logic [NUM_PINS-1:0] mode_q,
  output logic [NUM_PINS-1:0] pin_level,
  output logic [NUM_PINS-1:0] req_set
);
  logic [NUM_PINS-1:0] sync_lvl;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    rts_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (pin_n[g]),
      .dout (sync_lvl[g])
    );
  end

  rts_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_mode (cfg_mode),
    .wr_en    (cfg_wr),
    .wr_data  (cfg_wdata),
    .mode_q   (mode_q)
  );

  rts_fall #(.NUM_PINS(NUM_PINS)) u_fall (
    .clk   (clk),
    .rst   (rst),
    .lvl   (sync_lvl),
    .mode  (mode_q),
    .req_q (req_set)
  );

  assign pin_level = sync_lvl;

  // R3
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    |req_set |=> ((req_set & $past(req_set)) == '0));

  // R5
  gpio_silent_chk: assert property (@(posedge clk) disable iff (rst)
    |req_set |-> ((req_set & ~$past(mode_q)) == '0));
endmodule

// File: tb/sim_rts_pin_if.sv
module sim_rts_pin_if;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] pin_n;
  logic         cfg_mode, cfg_wr;
  logic [N-1:0] cfg_wdata;
  logic [N-1:0] mode_q, pin_level, req_set;

  int total = 0;
  int bad   = 0;
  int pulses [N];
  bit done = 0;

  always #10 clk = ~clk;

  rts_pin_if u0 (
    .clk(clk), .rst(rst), .pin_n(pin_n), .cfg_mode(cfg_mode),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .mode_q(mode_q),
    .pin_level(pin_level), .req_set(req_set)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic watch(input int n);
    for (int k = 0; k < N; k++) pulses[k] = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      for (int k = 0; k < N; k++) if (req_set[k]) pulses[k]++;
    end
  endtask

  task automatic write_mode(input logic en, input logic [N-1:0] d);
    @(negedge clk);
    cfg_mode = en; cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_mode = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R8 mode", mode_q, 0);
    chk("R8 req", req_set, 0);
    chk("R8 level", pin_level, 3'b111);
  endtask

  task automatic t_cfg_lock();
    write_mode(1'b0, 3'b111);
    chk("R6 ignored write", mode_q, 0);
    write_mode(1'b1, 3'b111);
    chk("R2 mode readback", mode_q, 3'b111);
  endtask

  task automatic t_latency();
    @(negedge clk); pin_n[0] = 1'b0;
    @(negedge clk);
    chk("R7 level not yet", pin_level[0], 1);
    chk("R3 edge1", req_set, 0);
    @(negedge clk);
    chk("R7 level low", pin_level[0], 0);
    chk("R3 edge2", req_set, 0);
    @(negedge clk);
    chk("R3 R1 pulse", req_set, 3'b001);
    @(negedge clk);
    chk("R3 pulse ends", req_set, 0);
  endtask

  task automatic t_hold();
    watch(20);
    chk("R4 held low", pulses[0], 0);
    pin_n[0] = 1'b1;
    watch(5);
    pin_n[0] = 1'b0;
    watch(8);
    chk("R4 new fall", pulses[0], 1);
    pin_n[0] = 1'b1;
    watch(5);
  endtask

  task automatic t_multi();
    @(negedge clk); pin_n[2:1] = 2'b00;
    watch(8);
    chk("R1 pin0 quiet", pulses[0], 0);
    chk("R1 pin1", pulses[1], 1);
    chk("R1 pin2", pulses[2], 1);
    pin_n = 3'b111;
    watch(5);
  endtask

  task automatic t_digital();
    write_mode(1'b1, 3'b011);
    chk("R2 mode 011", mode_q, 3'b011);
    pin_n[2] = 1'b0;
    watch(6);
    chk("R5 no pulse", pulses[2], 0);
    chk("R7 digital level", pin_level[2], 0);
    pin_n[2] = 1'b1;
    watch(3);
    pin_n[2] = 1'b0;
    watch(6);
    chk("R5 second fall", pulses[2], 0);
    pin_n[2] = 1'b1;
    watch(4);
    chk("R7 digital high", pin_level[2], 1);
  endtask

  task automatic t_reset_low();
    pin_n = 3'b000;
    do_reset();
    watch(5);
    write_mode(1'b1, 3'b111);
    watch(10);
    chk("R8 low at reset pin0", pulses[0], 0);
    chk("R8 low at reset pin1", pulses[1], 0);
    chk("R8 low at reset pin2", pulses[2], 0);
    pin_n = 3'b111;
    watch(5);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; pin_n = '1; cfg_mode = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0;
    t_reset();
    t_cfg_lock();
    t_latency();
    t_hold();
    t_multi();
    t_digital();
    t_reset_low();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end
endmodule